// File: doc/BRIEF.md
# Halfband Decimate/Interpolate Filter

This block is a fixed-coefficient halfband FIR filter with 67 taps for a real stream of 16-bit two's-complement samples. A 2-bit mode input selects the rate change. In decimate mode the block emits one filtered sample for every two accepted input samples. In interpolate mode it emits two filtered samples for every accepted input sample.

All coefficients at an even distance from the centre are zero, so the filter splits into two branches. One branch holds the 34 non-zero outer taps, folded into 17 symmetric pairs that are pre-added and then multiplied. The other branch is the centre tap, value one half, on a pure sample delay. Both modes share one sample delay line, and only the taps feeding each pair change with the mode.

The wide sum is rounded at a runtime-selected bit position and saturated to 16 bits. The result can be given in two's-complement or offset-binary form. A realignment input restarts the decimation pairing.

Top module: `halfband_filter`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `dout` is 0 until the first computed result. Reset also clears the sample history to zero.
- R2: The tap at index j (0..66) at distance d = j-33 has the coefficient h(j). For d = 0, h(j) = 16384. For even non-zero d, h(j) = 0. For odd d, h(j) = s*floor(10430/|d|), where s = +1 when (|d|-1)/2 is even and s = -1 otherwise.
- R3: In mode 00 (decimate), the accumulator for a result produced at accepted sample x[k] is the sum over j of h(j)*x[k-j]. Samples older than reset count as zero.
- R4: In mode 00, results are produced on the second, fourth, sixth and later accepted samples after reset or after a realignment. `out_valid` pulses for one cycle, two clock edges after the edge that accepts the producing sample.
- R5: A cycle with `sync` = 1 restarts pairing. If `in_valid` is also 1 in that cycle, that sample counts as the first of a new pair and produces no result. A `sync` cycle without a sample makes the next accepted sample the first of a pair.
- R6: In mode 01 (interpolate), accepted sample x[n] yields two results in this order. The first is 2*sum over m = 0..33 of h(2m)*x[n-m]. The second is 2*16384*x[n-16].
- R7: In mode 01, the two results appear on consecutive cycles, two and three edges after the accepting edge. Samples must be at least two cycles apart.
- R8: With s = 12 + `rnd`, the output value is floor((acc + 2^(s-1)) / 2^s). `rnd` = 3 therefore gives unity gain.
- R9: A rounded value above 32767 gives 32767, and a value below -32768 gives -32768.
- R10: With `fmt` = 1, bit 15 of the saturated two's-complement result is inverted (offset binary). With `fmt` = 0 the result is unchanged.
- R11: Mode codes 10 and 11 never raise `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 decimate, 01 interpolate, 10/11 no output |
| in_valid | input | 1 | Qualifies `din` for one sample |
| sync | input | 1 | Restarts decimation pairing |
| din | input | 16 | Input sample, two's complement |
| rnd | input | 3 | Rounding position select |
| fmt | input | 1 | 0 two's complement, 1 offset binary output |
| out_valid | output | 1 | Qualifies `dout` |
| dout | output | 16 | Filtered, rounded, saturated sample |

## Verification
A realignment request and a sample strobe can fall in the same cycle. The sample must then open a new pair rather than close the old one. The bench drives `sync` together with `in_valid`, both on what would have been the second sample of a pair and on what would have been a first. It also drives `sync` alone in the middle of a pair. A bench-side pairing model predicts which accepted samples produce results. Every result's value and arrival cycle are compared against a direct 67-tap convolution in the bench. A missing result or an extra one at any of these points counts as a failure.

// File: rtl/halfband_pkg.sv
package halfband_pkg;

   localparam int COEF_W    = 16;
   localparam int CTR_COEF  = 16384;
   localparam int INV_PI_Q  = 10430;

   typedef enum logic [1:0] {
      MODE_DEC  = 2'b00,
      MODE_INT  = 2'b01,
      MODE_RSV2 = 2'b10,
      MODE_RSV3 = 2'b11
   } hb_mode_e;

   // coefficient at positive odd distance d from the centre
   function automatic int odd_coef(input int d);
      int mag;
      mag = INV_PI_Q / d;
      return ((((d - 1) / 2) % 2) == 0) ? mag : -mag;
   endfunction

endpackage

// File: rtl/hb_delay_line.sv
module hb_delay_line #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 67
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         shift,
   input  logic [DATA_W-1:0]            din,
   output logic [DEPTH-1:0][DATA_W-1:0] taps
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("hb_delay_line: DEPTH must be at least 2");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     taps[g] <= '0;
            else if (shift) taps[g] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     taps[g] <= '0;
            else if (shift) taps[g] <= taps[g-1];
         end
      end
   end

   // R3: each accepted sample enters the history and the oldest moves along
   assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (taps[0] == $past(din)) && (taps[DEPTH-1] == $past(taps[DEPTH-2])));

endmodule

// File: rtl/hb_tap_sum.sv
module hb_tap_sum
   import halfband_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NTAPS  = 67,
   parameter int ACC_W  = 39
) (
   input  logic [NTAPS-1:0][DATA_W-1:0] taps,
   input  logic                         interp,
   output logic signed [ACC_W-1:0]      odd_sum,
   output logic signed [ACC_W-1:0]      ctr_term
);

   localparam int CENTER = (NTAPS - 1) / 2;
   localparam int NPAIR  = (NTAPS + 1) / 4;
   localparam int PRE_W  = DATA_W + 1;
   localparam int PROD_W = PRE_W + COEF_W;
   localparam int CPR_W  = DATA_W + COEF_W;
   localparam logic signed [COEF_W-1:0] CTR_Q = COEF_W'(CTR_COEF);

   logic [NPAIR-1:0][PROD_W-1:0] prods;

   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      localparam logic signed [COEF_W-1:0] CQ = COEF_W'(odd_coef(CENTER - 2 * i));
      logic signed [DATA_W-1:0] near_s;
      logic signed [DATA_W-1:0] far_s;
      logic signed [PRE_W-1:0]  pre;
      logic signed [PROD_W-1:0] prod;

      // interpolate pairs x[n-i] with x[n-(CENTER-i)]; decimate pairs taps 2i and NTAPS-1-2i
      always_comb begin
         near_s = interp ? $signed(taps[i])          : $signed(taps[2*i]);
         far_s  = interp ? $signed(taps[CENTER - i]) : $signed(taps[NTAPS-1-2*i]);
         pre    = PRE_W'(near_s) + PRE_W'(far_s);
         prod   = pre * CQ;
      end
      assign prods[i] = prod;
   end

   always_comb begin
      odd_sum = '0;
      for (int k = 0; k < NPAIR; k++) begin
         odd_sum = odd_sum + {{(ACC_W-PROD_W){prods[k][PROD_W-1]}}, prods[k]};
      end
   end

   logic signed [DATA_W-1:0] ctr_smp;
   logic signed [CPR_W-1:0]  ctr_prod;

   always_comb begin
      ctr_smp  = interp ? $signed(taps[(CENTER-1)/2]) : $signed(taps[CENTER]);
      ctr_prod = ctr_smp * CTR_Q;
      ctr_term = {{(ACC_W-CPR_W){ctr_prod[CPR_W-1]}}, ctr_prod};
   end

endmodule

// File: rtl/hb_round_sat.sv
module hb_round_sat #(
   parameter int ACC_W      = 39,
   parameter int OUT_W      = 16,
   parameter int RND_W      = 3,
   parameter int SHIFT_BASE = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_v,
   input  logic signed [ACC_W-1:0] acc,
   input  logic [RND_W-1:0]        rnd,
   input  logic                    fmt,
   output logic                    out_v,
   output logic [OUT_W-1:0]        dout
);

   localparam int MAX_SH = SHIFT_BASE + (2 ** RND_W) - 1;
   localparam int SH_W   = $clog2(MAX_SH + 1) + 1;
   localparam logic signed [ACC_W-1:0] MAXV   = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] MINV   = ~MAXV;
   localparam logic signed [ACC_W-1:0] SAT_TH = ACC_W'(1) << (SHIFT_BASE + OUT_W - 1);

   if (SHIFT_BASE < 1 || MAX_SH + OUT_W > ACC_W) begin : g_bad_shift
      $error("hb_round_sat: rounding range does not fit the accumulator");
   end

   logic [SH_W-1:0]         sh;
   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] shifted;
   logic [OUT_W-1:0]        sat;

   always_comb begin
      sh      = SH_W'(SHIFT_BASE) + SH_W'(rnd);
      biased  = acc + (ACC_W'(1) << (sh - SH_W'(1)));
      shifted = biased >>> sh;
      if (shifted > MAXV)      sat = MAXV[OUT_W-1:0];
      else if (shifted < MINV) sat = MINV[OUT_W-1:0];
      else                     sat = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         dout  <= '0;
      end else begin
         out_v <= in_v;
         if (in_v) dout <= {sat[OUT_W-1] ^ fmt, sat[OUT_W-2:0]};
      end
   end

   // R9: a large positive sum at the finest position clips to the top code
   assert_sat_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && !fmt && rnd == '0 && acc >= SAT_TH) |=> dout == {1'b0, {(OUT_W-1){1'b1}}});

   // R10: zero in offset binary is the mid code
   assert_offset_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && fmt && acc == '0) |=> dout == {1'b1, {(OUT_W-1){1'b0}}});

endmodule

// File: rtl/halfband_filter.sv
module halfband_filter
   import halfband_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int NTAPS      = 67,
   parameter int RND_W      = 3,
   parameter int SHIFT_BASE = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              in_valid,
   input  logic              sync,
   input  logic [DATA_W-1:0] din,
   input  logic [RND_W-1:0]  rnd,
   input  logic              fmt,
   output logic              out_valid,
   output logic [DATA_W-1:0] dout
);

   localparam int NPAIR = (NTAPS + 1) / 4;
   localparam int ACC_W = DATA_W + COEF_W + $clog2(NPAIR + 1) + 2;

   if ((NTAPS % 4) != 3 || NTAPS < 7) begin : g_bad_taps
      $error("halfband_filter: NTAPS must be 4k+3 and at least 7");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("halfband_filter: DATA_W too small");
   end

   hb_mode_e mode_e;
   logic     is_dec, is_int;
   assign mode_e = hb_mode_e'(mode);
   assign is_dec = (mode_e == MODE_DEC);
   assign is_int = (mode_e == MODE_INT);

   // decimation pairing: phase 1 means the next sample closes a pair
   logic phase;
   logic dec_fire, int_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 phase <= 1'b0;
      else if (sync)              phase <= in_valid & is_dec;
      else if (in_valid & is_dec) phase <= ~phase;
   end

   assign dec_fire = in_valid & is_dec & phase & ~sync;
   assign int_fire = in_valid & is_int;

   logic [NTAPS-1:0][DATA_W-1:0] taps;

   hb_delay_line #(.DATA_W(DATA_W), .DEPTH(NTAPS)) u_hist (
      .clk  (clk),
      .rst_n(rst_n),
      .shift(in_valid),
      .din  (din),
      .taps (taps)
   );

   logic calc_q, calc_int_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         calc_q     <= 1'b0;
         calc_int_q <= 1'b0;
      end else begin
         calc_q     <= dec_fire | int_fire;
         calc_int_q <= int_fire;
      end
   end

   logic signed [ACC_W-1:0] odd_sum, ctr_term;

   hb_tap_sum #(.DATA_W(DATA_W), .NTAPS(NTAPS), .ACC_W(ACC_W)) u_taps (
      .taps    (taps),
      .interp  (calc_int_q),
      .odd_sum (odd_sum),
      .ctr_term(ctr_term)
   );

   // accumulator stage; the centre result of an interpolated pair waits one cycle
   logic                    acc_v, hold_v;
   logic signed [ACC_W-1:0] acc_q, hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_v  <= 1'b0;
         hold_v <= 1'b0;
         acc_q  <= '0;
         hold_q <= '0;
      end else begin
         acc_v  <= calc_q | hold_v;
         hold_v <= calc_q & calc_int_q;
         if (calc_q) begin
            acc_q <= calc_int_q ? (odd_sum <<< 1) : (odd_sum + ctr_term);
         end else if (hold_v) begin
            acc_q <= hold_q;
         end
         if (calc_q & calc_int_q) hold_q <= ctr_term <<< 1;
      end
   end

   hb_round_sat #(
      .ACC_W(ACC_W), .OUT_W(DATA_W), .RND_W(RND_W), .SHIFT_BASE(SHIFT_BASE)
   ) u_round (
      .clk  (clk),
      .rst_n(rst_n),
      .in_v (acc_v),
      .acc  (acc_q),
      .rnd  (rnd),
      .fmt  (fmt),
      .out_v(out_valid),
      .dout (dout)
   );

   // R4: a decimated result is never followed by another on the next cycle
   assert_dec_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_q && !calc_int_q) |=> !calc_q);

   // R7: an interpolated sample yields two back-to-back accumulator results
   assert_int_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_q && calc_int_q) |=> acc_v ##1 acc_v);

   // R11: samples in the unused mode codes start no computation
   assert_rsv_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode[1]) |=> !calc_q);

   // R5: a sample arriving with sync never closes a pair
   assert_sync_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sync && is_dec) |=> !calc_q);

endmodule

// File: tb/halfband_filter_tb_top.sv
module halfband_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic        in_valid, sync;
   logic [15:0] din;
   logic [2:0]  rnd;
   logic        fmt;
   logic        out_valid;
   logic [15:0] dout;

   always #5 clk = ~clk;

   halfband_filter dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .sync(sync),
      .din(din), .rnd(rnd), .fmt(fmt), .out_valid(out_valid), .dout(dout)
   );

   int    errs = 0, checks = 0;
   int    cyc = 0;
   bit    done = 0;
   bit    phase = 0;
   int    hist[$];
   int    exp_v[$];
   int    exp_t[$];
   string exp_r[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // R2 coefficient formula
   function automatic longint h(input int j);
      int d, ad, mag;
      d = j - 33;
      if (d == 0) return 16384;
      if (d % 2 == 0) return 0;
      ad = (d < 0) ? -d : d;
      mag = 10430 / ad;
      return ((((ad - 1) / 2) % 2) == 0) ? mag : -mag;
   endfunction

   function automatic longint xs(input int back);
      int idx;
      idx = hist.size() - 1 - back;
      return (idx < 0) ? 0 : hist[idx];
   endfunction

   // R8/R9/R10 output shaping
   function automatic int shape(input longint acc, input int r, input bit f);
      int     s;
      longint v;
      int     res;
      s = 12 + r;
      v = (acc + (64'sd1 <<< (s - 1))) >>> s;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      res = int'(v) & 16'hFFFF;
      if (f) res = res ^ 16'h8000;
      return res;
   endfunction

   task automatic push_exp(input int v, input int t, input string r);
      exp_v.push_back(v);
      exp_t.push_back(t);
      exp_r.push_back(r);
   endtask

   task automatic put(input int v, input bit s);
      longint acc;
      @(negedge clk);
      din = 16'(v); in_valid = 1'b1; sync = s;
      hist.push_back(v);
      if (mode == 2'b00) begin
         if (s) phase = 0;
         if (phase) begin
            acc = 0;
            for (int j = 0; j < 67; j++) acc += h(j) * xs(j);
            push_exp(shape(acc, rnd, fmt), cyc + 3, s ? "R5" : "R3");
         end
         phase = ~phase;
      end else if (mode == 2'b01) begin
         acc = 0;
         for (int m = 0; m < 34; m++) acc += h(2 * m) * xs(m);
         push_exp(shape(2 * acc, rnd, fmt), cyc + 3, "R6");
         push_exp(shape(2 * 16384 * xs(16), rnd, fmt), cyc + 4, "R7");
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0; sync = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic sync_only();
      @(negedge clk);
      in_valid = 1'b0; sync = 1'b1;
      phase = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; sync = 1'b0; din = '0;
      hist.delete(); exp_v.delete(); exp_t.delete(); exp_r.delete();
      phase = 0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && dout == 16'h0, "R1 in reset", dout, 0);
      rst_n = 1'b1;
   endtask

   task automatic drain(input string tag);
      idle(8);
      chk(exp_v.size() == 0, tag, exp_v.size(), 0);
   endtask

   function automatic int lfsr_val(input int lim);
      return $signed($urandom_range(2 * lim, 0)) - lim;
   endfunction

   // output monitor
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (exp_v.size() == 0) begin
            chk(1'b0, mode[1] ? "R11 output in unused mode" : "R4 unexpected output", dout, -1);
         end else begin
            int    v, t;
            string r;
            v = exp_v.pop_front(); t = exp_t.pop_front(); r = exp_r.pop_front();
            chk(int'(dout) == v, r, dout, v);
            chk(cyc == t, (r == "R7") ? "R7 latency" : "R4 latency", cyc, t);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         errs++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      mode = 2'b00; rnd = 3'd3; fmt = 1'b0;
      do_reset();
      @(negedge clk);
      chk(out_valid == 1'b0 && dout == 16'h0, "R1 after reset", dout, 0);

      // R2/R3 impulse in decimate mode exposes the coefficient set
      put(16384, 0);
      for (int i = 0; i < 80; i++) put(0, 0);
      drain("R3 missing impulse result");

      // R3/R4 mixed stream with gaps
      do_reset();
      for (int i = 0; i < 160; i++) begin
         put(lfsr_val(20000), 0);
         if ($urandom_range(3, 0) == 0) idle($urandom_range(3, 1));
      end
      drain("R3 missing decimated result");

      // R5 realignment together with and apart from samples
      do_reset();
      for (int i = 0; i < 9; i++) put(lfsr_val(30000), 0);
      put(lfsr_val(30000), 1);
      put(lfsr_val(30000), 0);
      put(lfsr_val(30000), 1);
      put(lfsr_val(30000), 1);
      put(lfsr_val(30000), 0);
      put(lfsr_val(30000), 0);
      sync_only();
      put(lfsr_val(30000), 0);
      put(lfsr_val(30000), 0);
      put(lfsr_val(30000), 0);
      sync_only();
      idle(2);
      for (int i = 0; i < 7; i++) put(lfsr_val(30000), 0);
      drain("R5 missing realigned result");

      // R6/R7 interpolate
      mode = 2'b01;
      do_reset();
      for (int i = 0; i < 90; i++) begin
         put(lfsr_val(32000), 0);
         idle($urandom_range(3, 1));
      end
      drain("R6 missing interpolated result");

      // R8/R9/R10 rounding position sweep with clipping and both formats
      mode = 2'b00;
      do_reset();
      for (int r = 0; r < 8; r++) begin
         rnd = 3'(r); fmt = r[0];
         for (int i = 0; i < 70; i++) put(32767, 0);
         for (int i = 0; i < 70; i++) put(-32768, 0);
         for (int i = 0; i < 20; i++) put(lfsr_val(3000), 0);
         drain("R8 missing rounded result");
      end

      // R11 unused mode codes
      rnd = 3'd3; fmt = 1'b0;
      for (int c = 2; c < 4; c++) begin
         mode = 2'(c);
         do_reset();
         for (int i = 0; i < 30; i++) put(lfsr_val(32000), i % 5 == 0);
         idle(6);
         chk(out_valid == 1'b0 && dout == 16'h0, "R11 unused mode quiet", dout, 0);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule